// File: doc/BRIEF.md
# DMA Interrupt Status Register

This block keeps the interrupt and event status for a descriptor-based DMA engine inside a card host controller. The DMA datapath sends it single-cycle event pulses: a descriptor finished transmitting, a descriptor finished receiving, a fatal bus error (with a 3-bit error type), and a descriptor that could not be used because the DMA did not own it. A vector of card error flags is also fed in. Each event sets a sticky status bit. Two sticky summary bits collect the unmasked causes. The *normal* summary covers transfer completions and the *abnormal* summary covers error conditions.

Software reads one 32-bit status word and clears bits by writing ones to them. A fatal bus error holds the bus-access disable output high until software clears that bit. The error type is captured with the error and stays readable while the bit is set. The word also mirrors the current state of the DMA state machine. A single interrupt line is raised while an enabled summary bit is set.

Top module: `dma_irq_status`

## Requirements
- R1: After a synchronous reset, the status word reads 0 and `irq` and `bus_disable` are low.
- R2: A pulse on `ev_tx_done` sets bit 0 and a pulse on `ev_rx_done` sets bit 1. Each bit is visible on the cycle after the pulse.
- R3: A pulse on `ev_bus_err` sets bit 2. `bus_disable` is high exactly while bit 2 is set.
- R4: Bits 12:10 take `ev_bus_err_code` on the cycle bit 2 goes from 0 to 1. Later bus errors do not change the field while bit 2 stays set. The field reads 0 whenever bit 2 is clear.
- R5: A pulse on `ev_desc_unavail` sets bit 4.
- R6: Bit 5 is set on any cycle in which any bit of `card_err` is high.
- R7: Writing a 1 to bit 0, 1, 2, 4, 5, 8 or 9 clears that bit. Writing 0s, or writing to reserved or read-only positions, changes nothing. An event that arrives in the same cycle as a clearing write leaves its bit set.
- R8: Bit 8 becomes set when bit 0 or bit 1 is set and its enable (`irq_mask` bit 0 or bit 1) is 1. Causes whose enable is 0 do not set bit 8.
- R9: Bit 9 becomes set when bit 2, 4 or 5 is set and its enable (`irq_mask` bit 2, 4 or 5) is 1. Causes whose enable is 0 do not set bit 9.
- R10: Bits 8 and 9 stay set after their causes are cleared or masked, until software writes a 1 to them.
- R11: `irq` is high on a cycle when (bit 8 AND the previous cycle's `irq_mask[8]`) OR (bit 9 AND the previous cycle's `irq_mask[9]`).
- R12: Bits 16:13 show the `dma_state` value from the previous cycle. Bits 31:17, 7:6 and 3 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_tx_done | input | 1 | Pulse: transmit finished for one descriptor |
| ev_rx_done | input | 1 | Pulse: receive finished for one descriptor |
| ev_bus_err | input | 1 | Pulse: fatal bus error |
| ev_bus_err_code | input | CODE_W | Error type that comes with `ev_bus_err` |
| ev_desc_unavail | input | 1 | Pulse: fetched descriptor not owned by the DMA |
| card_err | input | CARD_ERR_W | Card error flags (end bit, timeouts, CRC, start bit, response error) |
| dma_state | input | STATE_W | Current DMA state-machine state |
| irq_mask | input | 10 | Enable per status bit, at the same position as the bit it enables |
| reg_wr | input | 1 | Write strobe for the status word |
| reg_wdata | input | 32 | Write data; a 1 clears the matching bit |
| reg_rdata | output | 32 | Status word |
| irq | output | 1 | Interrupt request |
| bus_disable | output | 1 | Blocks DMA bus access after a fatal bus error |

## Verification
The bench targets these corner cases:

- **Event and clear in the same cycle.** A design where the clear wins would drop a completion.
- **Clearing a summary bit and its cause in one write.** A design that sets the summary from the old cause value would re-raise the summary.
- **A second bus error while the first is still pending.** A design that recaptures on every error would overwrite the original type.
- **Unmasking a cause that is already set, and masking a summary that is already set.** A design that is not sticky would drop the summary. A design that ignores the mask would assert `irq`.

A randomized run then compares every cycle against a behavioural model. This catches wrong bit positions, a missing reserved-zero, and an off-by-one in the state mirror.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int REG_W     = 32;
  localparam int MASK_W    = 10;
  localparam int NUM_CAUSE = 5;

  // cause indices inside the sticky cause vector
  localparam int CZ_TX     = 0;
  localparam int CZ_RX     = 1;
  localparam int CZ_BUSERR = 2;
  localparam int CZ_NODESC = 3;
  localparam int CZ_CARD   = 4;

  // positions in the status word that software decodes
  localparam int NIS_POS   = 8;
  localparam int AIS_POS   = 9;
  localparam int CODE_LSB  = 10;
  localparam int FSM_LSB   = 13;

  localparam logic [NUM_CAUSE-1:0] NORMAL_GRP   = 5'b00011;
  localparam logic [NUM_CAUSE-1:0] ABNORMAL_GRP = 5'b11100;

  function automatic int cause_pos(input int idx);
    case (idx)
      CZ_TX:     return 0;
      CZ_RX:     return 1;
      CZ_BUSERR: return 2;
      CZ_NODESC: return 4;
      default:   return 5;
    endcase
  endfunction
endpackage

// File: rtl/dma_irq_sticky.sv
module dma_irq_sticky #(
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o,
  output logic [N-1:0] nxt_o
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_bit
      // set has priority over a clear in the same cycle
      assign nxt_o[g] = set_i[g] | (q_o[g] & ~clr_i[g]);
      always_ff @(posedge clk) begin
        if (rst) q_o[g] <= 1'b0;
        else     q_o[g] <= nxt_o[g];
      end
    end
  endgenerate
endmodule

// File: rtl/dma_irq_errcode.sv
module dma_irq_errcode #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              err_held_i,
  input  logic              err_nxt_i,
  input  logic              err_evt_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] code_o
);
  always_ff @(posedge clk) begin
    if (rst || !err_nxt_i)
      code_o <= '0;
    else if (!err_held_i && err_evt_i)
      code_o <= code_i;
  end
endmodule

// File: rtl/dma_irq_summary.sv
module dma_irq_summary
  import dma_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CAUSE-1:0] cause_nxt_i,
  input  logic [NUM_CAUSE-1:0] cause_en_i,
  input  logic                 nis_clr_i,
  input  logic                 ais_clr_i,
  input  logic                 nis_irq_en_i,
  input  logic                 ais_irq_en_i,
  output logic                 nis_o,
  output logic                 ais_o,
  output logic                 irq_o
);
  logic [NUM_CAUSE-1:0] live;
  logic [1:0]           sum_set, sum_clr, sum_q, sum_nxt;

  assign live    = cause_nxt_i & cause_en_i;
  assign sum_set = {|(live & ABNORMAL_GRP), |(live & NORMAL_GRP)};
  assign sum_clr = {ais_clr_i, nis_clr_i};

  dma_irq_sticky #(.N(2)) u_sum_bits (
    .clk   (clk),
    .rst   (rst),
    .set_i (sum_set),
    .clr_i (sum_clr),
    .q_o   (sum_q),
    .nxt_o (sum_nxt)
  );

  assign nis_o = sum_q[0];
  assign ais_o = sum_q[1];

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= (sum_nxt[0] & nis_irq_en_i) | (sum_nxt[1] & ais_irq_en_i);
  end
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
  import dma_irq_pkg::*;
#(
  parameter int CODE_W     = 3,
  parameter int STATE_W    = 4,
  parameter int CARD_ERR_W = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ev_tx_done,
  input  logic                  ev_rx_done,
  input  logic                  ev_bus_err,
  input  logic [CODE_W-1:0]     ev_bus_err_code,
  input  logic                  ev_desc_unavail,
  input  logic [CARD_ERR_W-1:0] card_err,
  input  logic [STATE_W-1:0]    dma_state,
  input  logic [MASK_W-1:0]     irq_mask,
  input  logic                  reg_wr,
  input  logic [REG_W-1:0]      reg_wdata,
  output logic [REG_W-1:0]      reg_rdata,
  output logic                  irq,
  output logic                  bus_disable
);
  logic [NUM_CAUSE-1:0] cause_set, cause_clr, cause_en, cause_q, cause_nxt;
  logic [CODE_W-1:0]    code_q;
  logic [STATE_W-1:0]   fsm_q;
  logic                 nis_q, ais_q;

  assign cause_set[CZ_TX]     = ev_tx_done;
  assign cause_set[CZ_RX]     = ev_rx_done;
  assign cause_set[CZ_BUSERR] = ev_bus_err;
  assign cause_set[CZ_NODESC] = ev_desc_unavail;
  assign cause_set[CZ_CARD]   = |card_err;

  genvar g;
  generate
    for (g = 0; g < NUM_CAUSE; g++) begin : g_map
      assign cause_clr[g] = reg_wr & reg_wdata[cause_pos(g)];
      assign cause_en[g]  = irq_mask[cause_pos(g)];
    end
  endgenerate

  dma_irq_sticky #(.N(NUM_CAUSE)) u_causes (
    .clk   (clk),
    .rst   (rst),
    .set_i (cause_set),
    .clr_i (cause_clr),
    .q_o   (cause_q),
    .nxt_o (cause_nxt)
  );

  dma_irq_errcode #(.CODE_W(CODE_W)) u_errcode (
    .clk        (clk),
    .rst        (rst),
    .err_held_i (cause_q[CZ_BUSERR]),
    .err_nxt_i  (cause_nxt[CZ_BUSERR]),
    .err_evt_i  (ev_bus_err),
    .code_i     (ev_bus_err_code),
    .code_o     (code_q)
  );

  dma_irq_summary u_summary (
    .clk          (clk),
    .rst          (rst),
    .cause_nxt_i  (cause_nxt),
    .cause_en_i   (cause_en),
    .nis_clr_i    (reg_wr & reg_wdata[NIS_POS]),
    .ais_clr_i    (reg_wr & reg_wdata[AIS_POS]),
    .nis_irq_en_i (irq_mask[NIS_POS]),
    .ais_irq_en_i (irq_mask[AIS_POS]),
    .nis_o        (nis_q),
    .ais_o        (ais_q),
    .irq_o        (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) fsm_q <= '0;
    else     fsm_q <= dma_state;
  end

  // status word is assembled purely from flops
  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_CAUSE; i++)
      reg_rdata[cause_pos(i)] = cause_q[i];
    reg_rdata[NIS_POS]                = nis_q;
    reg_rdata[AIS_POS]                = ais_q;
    reg_rdata[CODE_LSB +: CODE_W]     = code_q;
    reg_rdata[FSM_LSB +: STATE_W]     = fsm_q;
  end

  assign bus_disable = cause_q[CZ_BUSERR];

  logic unused_bits;
  assign unused_bits = ^{reg_wdata[REG_W-1:AIS_POS+1], reg_wdata[7:6], reg_wdata[3],
                         irq_mask[7:6], irq_mask[3]};
endmodule

// File: rtl/dma_irq_status_chk.sv
module dma_irq_status_chk
  import dma_irq_pkg::*;
#(
  parameter int CODE_W     = 3,
  parameter int STATE_W    = 4,
  parameter int CARD_ERR_W = 7
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  ev_tx_done,
  input logic                  ev_rx_done,
  input logic                  ev_bus_err,
  input logic [CODE_W-1:0]     ev_bus_err_code,
  input logic                  ev_desc_unavail,
  input logic [CARD_ERR_W-1:0] card_err,
  input logic [STATE_W-1:0]    dma_state,
  input logic [MASK_W-1:0]     irq_mask,
  input logic                  reg_wr,
  input logic [REG_W-1:0]      reg_wdata,
  input logic [REG_W-1:0]      reg_rdata,
  input logic                  irq,
  input logic                  bus_disable
);
  logic unused_chk;
  assign unused_chk = ^{reg_wdata, irq_mask};

  p_tx_sets_r2: assert property (@(posedge clk) disable iff (rst)
    ev_tx_done |=> reg_rdata[0]);
  p_rx_sets_r2: assert property (@(posedge clk) disable iff (rst)
    ev_rx_done |=> reg_rdata[1]);
  p_buserr_blocks_r3: assert property (@(posedge clk) disable iff (rst)
    ev_bus_err |=> bus_disable);
  p_code_capture_r4: assert property (@(posedge clk) disable iff (rst)
    (ev_bus_err && !reg_rdata[2]) |=> (reg_rdata[CODE_LSB +: CODE_W] == $past(ev_bus_err_code)));
  p_code_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata[2] && !(reg_wr && reg_wdata[2])) |=> $stable(reg_rdata[CODE_LSB +: CODE_W]));
  p_code_zero_r4: assert property (@(posedge clk) disable iff (rst)
    !reg_rdata[2] |-> (reg_rdata[CODE_LSB +: CODE_W] == '0));
  p_desc_sets_r5: assert property (@(posedge clk) disable iff (rst)
    ev_desc_unavail |=> reg_rdata[4]);
  p_card_sets_r6: assert property (@(posedge clk) disable iff (rst)
    (|card_err) |=> reg_rdata[5]);
  p_w1c_r7: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata[0] && reg_wr && reg_wdata[0] && !ev_tx_done) |=> !reg_rdata[0]);
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata[1] && !(reg_wr && reg_wdata[1])) |=> reg_rdata[1]);
  p_nis_masked_r8: assert property (@(posedge clk) disable iff (rst)
    (!reg_rdata[NIS_POS] && !irq_mask[0] && !irq_mask[1]) |=> !reg_rdata[NIS_POS]);
  p_ais_masked_r9: assert property (@(posedge clk) disable iff (rst)
    (!reg_rdata[AIS_POS] && !irq_mask[2] && !irq_mask[4] && !irq_mask[5]) |=> !reg_rdata[AIS_POS]);
  p_nis_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata[NIS_POS] && !(reg_wr && reg_wdata[NIS_POS])) |=> reg_rdata[NIS_POS]);
  p_ais_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata[AIS_POS] && !(reg_wr && reg_wdata[AIS_POS])) |=> reg_rdata[AIS_POS]);
  p_irq_r11: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq == ((reg_rdata[NIS_POS] && $past(irq_mask[NIS_POS])) ||
                             (reg_rdata[AIS_POS] && $past(irq_mask[AIS_POS])))));
  p_fsm_mirror_r12: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (reg_rdata[FSM_LSB +: STATE_W] == $past(dma_state)));
  p_reserved_r12: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata[31:17] == '0) && (reg_rdata[7:6] == 2'b00) && !reg_rdata[3]);
endmodule

bind dma_irq_status dma_irq_status_chk #(
  .CODE_W(CODE_W), .STATE_W(STATE_W), .CARD_ERR_W(CARD_ERR_W)
) u_chk (.*);

// File: tb/dma_irq_status_tb.sv
`timescale 1ns/1ps
module dma_irq_status_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ev_tx_done = 0, ev_rx_done = 0, ev_bus_err = 0, ev_desc_unavail = 0;
  logic [2:0]  ev_bus_err_code = 0;
  logic [6:0]  card_err = 0;
  logic [3:0]  dma_state = 0;
  logic [9:0]  irq_mask = 0;
  logic        reg_wr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        irq, bus_disable;

  int n_chk = 0, n_fail = 0;
  bit mon_en = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dma_irq_status u_dut (
    .clk(clk), .rst(rst), .ev_tx_done(ev_tx_done), .ev_rx_done(ev_rx_done),
    .ev_bus_err(ev_bus_err), .ev_bus_err_code(ev_bus_err_code),
    .ev_desc_unavail(ev_desc_unavail), .card_err(card_err), .dma_state(dma_state),
    .irq_mask(irq_mask), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .bus_disable(bus_disable)
  );

  // behavioural reference state
  bit m_tx, m_rx, m_fbe, m_du, m_ces, m_nis, m_ais, m_irq;
  int m_code, m_fsm;

  function automatic logic [31:0] model_word();
    logic [31:0] w = 0;
    w[0] = m_tx; w[1] = m_rx; w[2] = m_fbe; w[4] = m_du; w[5] = m_ces;
    w[8] = m_nis; w[9] = m_ais;
    w[12:10] = m_code[2:0];
    w[16:13] = m_fsm[3:0];
    return w;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      {m_tx, m_rx, m_fbe, m_du, m_ces, m_nis, m_ais, m_irq} = '0;
      m_code = 0; m_fsm = 0;
    end else begin
      logic [31:0] c;
      bit old_fbe;
      c = reg_wr ? reg_wdata : 32'h0;
      old_fbe = m_fbe;
      m_tx  = ev_tx_done      || (m_tx  && !c[0]);
      m_rx  = ev_rx_done      || (m_rx  && !c[1]);
      m_fbe = ev_bus_err      || (m_fbe && !c[2]);
      m_du  = ev_desc_unavail || (m_du  && !c[4]);
      m_ces = (card_err != 0) || (m_ces && !c[5]);
      if (!m_fbe) m_code = 0;
      else if (!old_fbe && ev_bus_err) m_code = ev_bus_err_code;
      m_nis = (m_tx && irq_mask[0]) || (m_rx && irq_mask[1]) || (m_nis && !c[8]);
      m_ais = (m_fbe && irq_mask[2]) || (m_du && irq_mask[4]) ||
              (m_ces && irq_mask[5]) || (m_ais && !c[9]);
      m_irq = (m_nis && irq_mask[8]) || (m_ais && irq_mask[9]);
      m_fsm = dma_state;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (mon_en && !done) begin
      check("R7 status word vs model", reg_rdata, model_word());
      check("R11 irq vs model", {31'b0, irq}, {31'b0, m_irq});
      check("R3 bus_disable vs model", {31'b0, bus_disable}, {31'b0, m_fbe});
    end
  end

  task automatic step();
    @(negedge clk);
    ev_tx_done = 0; ev_rx_done = 0; ev_bus_err = 0; ev_desc_unavail = 0;
    card_err = 0; reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic wr(input logic [31:0] d);
    reg_wr = 1; reg_wdata = d;
    step();
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog: actual=timeout expected=finish");
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    mon_en = 1;
    // R1 reset state
    check("R1 reset word", reg_rdata, 32'h0);
    check("R1 reset irq", {31'b0, irq}, 32'h0);
    check("R1 reset bus_disable", {31'b0, bus_disable}, 32'h0);

    // R2 transmit done with everything masked -> R8 no summary
    ev_tx_done = 1; step();
    check("R2 tx bit", {31'b0, reg_rdata[0]}, 32'h1);
    check("R8 masked tx leaves nis clear", {31'b0, reg_rdata[8]}, 32'h0);

    // enable tx/rx causes and normal summary
    irq_mask = 10'h103;
    ev_rx_done = 1; step();
    check("R2 rx bit", {31'b0, reg_rdata[1]}, 32'h1);
    check("R8 nis set by unmasked causes", {31'b0, reg_rdata[8]}, 32'h1);
    check("R11 irq with nis enabled", {31'b0, irq}, 32'h1);

    // clear causes only, summary stays
    wr(32'h3);
    check("R7 w1c clears bits 1:0", {30'b0, reg_rdata[1:0]}, 32'h0);
    check("R10 nis sticky after cause clear", {31'b0, reg_rdata[8]}, 32'h1);
    irq_mask = 10'h003; step();
    check("R11 irq drops with nis enable off", {31'b0, irq}, 32'h0);
    check("R10 nis still set", {31'b0, reg_rdata[8]}, 32'h1);
    wr(32'h100);
    check("R10 nis cleared by write", {31'b0, reg_rdata[8]}, 32'h0);

    // set wins over clear in the same cycle
    ev_tx_done = 1; reg_wr = 1; reg_wdata = 32'h1; step();
    check("R7 set wins over clear", {31'b0, reg_rdata[0]}, 32'h1);
    wr(32'hFFFF_FCC8);
    check("R7 write to reserved/ro is ignored", {23'b0, reg_rdata[8:0]}, 32'h101);
    wr(32'h101);
    check("R7 clear tx and nis together", {23'b0, reg_rdata[8:0]}, 32'h0);

    // fatal bus error
    irq_mask = 10'h234;
    ev_bus_err = 1; ev_bus_err_code = 3'd5; step();
    check("R3 fbe bit", {31'b0, reg_rdata[2]}, 32'h1);
    check("R3 bus_disable high", {31'b0, bus_disable}, 32'h1);
    check("R4 code captured", {29'b0, reg_rdata[12:10]}, 32'd5);
    check("R9 ais set", {31'b0, reg_rdata[9]}, 32'h1);
    check("R11 irq with ais enabled", {31'b0, irq}, 32'h1);
    ev_bus_err = 1; ev_bus_err_code = 3'd2; step();
    check("R4 second error keeps first code", {29'b0, reg_rdata[12:10]}, 32'd5);
    wr(32'h4);
    check("R3 bus_disable released", {31'b0, bus_disable}, 32'h0);
    check("R4 code zero once fbe clear", {29'b0, reg_rdata[12:10]}, 32'd0);
    check("R10 ais sticky", {31'b0, reg_rdata[9]}, 32'h1);
    wr(32'h200);
    check("R9 ais cleared", {31'b0, reg_rdata[9]}, 32'h0);
    check("R11 irq low", {31'b0, irq}, 32'h0);

    // descriptor unavailable while masked, then unmask
    irq_mask = 10'h000;
    ev_desc_unavail = 1; step();
    check("R5 desc bit", {31'b0, reg_rdata[4]}, 32'h1);
    check("R9 masked du leaves ais clear", {31'b0, reg_rdata[9]}, 32'h0);
    irq_mask = 10'h010; step();
    check("R9 unmasking standing du sets ais", {31'b0, reg_rdata[9]}, 32'h1);
    wr(32'h210);
    check("R7 du and ais cleared", {22'b0, reg_rdata[9:0]}, 32'h0);
    irq_mask = 10'h000;

    // every card error flag alone
    for (int k = 0; k < 7; k++) begin
      card_err = 7'(1 << k); step();
      check($sformatf("R6 card flag %0d sets bit 5", k), {31'b0, reg_rdata[5]}, 32'h1);
      wr(32'h20);
      check("R6 bit 5 cleared", {31'b0, reg_rdata[5]}, 32'h0);
    end

    // state mirror and reserved bits
    for (int k = 0; k < 16; k++) begin
      dma_state = 4'(k); step();
      check("R12 fsm mirror", {28'b0, reg_rdata[16:13]}, 32'(k));
      check("R12 reserved zero", {reg_rdata[31:17], 12'b0, reg_rdata[7:6], 2'b0, reg_rdata[3], 3'b0}, 32'h0);
    end

    // randomized run compared against the model each cycle
    for (int n = 0; n < 4000; n++) begin
      ev_tx_done      = ($urandom_range(7) == 0);
      ev_rx_done      = ($urandom_range(7) == 0);
      ev_bus_err      = ($urandom_range(15) == 0);
      ev_bus_err_code = 3'($urandom);
      ev_desc_unavail = ($urandom_range(11) == 0);
      card_err        = ($urandom_range(9) == 0) ? 7'($urandom) : 7'h0;
      dma_state       = 4'($urandom);
      if ($urandom_range(7) == 0) irq_mask = 10'($urandom);
      reg_wr          = ($urandom_range(3) == 0);
      reg_wdata       = $urandom;
      @(negedge clk);
    end
    step();

    done = 1;
    summary();
    $finish;
  end
endmodule